// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage Pipeline

This block decides, every cycle, whether the instruction sitting in decode may move on or must wait. An in-order integer pipeline reads its operands in decode and writes results back only in its last stage. A decode-stage instruction that names a register still awaiting a write from an older instruction would therefore read a stale value. The block keeps its own record of the writes that are still in flight: one slot each for the execute, memory and writeback stages. It compares both source register numbers of the decode instruction against that record.

When a match is found, the block holds the program counter and the fetch/decode register, and puts an empty slot into execute in place of the waiting instruction. The older instructions keep draining toward writeback. The record shifts on every clock edge, so the stall ends by itself once the producing write has left the record. A mode input selects a register file that writes in the first half of a cycle and reads in the second. In that mode the writeback slot no longer needs to be compared, and a dependence costs one cycle less.

Top module: `raw_stall_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, all three in-flight slots read as not pending (`ex_pend`, `mem_pend`, `wb_pend` are 0) and `hazard` is 0.
- R2: `hazard` is 1 when `dec_valid` is 1 and `dec_rs` is non-zero and equals the destination of a pending slot in execute, memory or writeback (writeback only when `split_rf` is 0).
- R3: The same rule applies to `dec_rt`. The six comparisons of R2 and R3 are combined by OR into the single `hazard` output.
- R4: A slot whose write enable was 0 when it issued is never pending and never causes a hazard, even when its destination matches.
- R5: When `split_rf` is 1, the writeback slot is excluded from the comparison. A producer that was in execute when the stall began then costs two stall cycles instead of three.
- R6: Register number 0 never causes a hazard, even when a pending slot targets register 0.
- R7: `hold_pc`, `hold_ifid` and `inject_bubble` equal `hazard` in the same cycle. At the next edge the execute slot becomes a non-pending bubble, and memory and writeback take the previous execute and memory slots.
- R8: In a cycle without hazard, the decode instruction issues at the next edge. `ex_rd` takes `dec_rd`, and `ex_pend` becomes `dec_valid & dec_wen`.
- R9: Each edge moves the memory slot into writeback and drops the old writeback slot. A write is no longer pending three edges after it entered execute.
- R10: When `dec_valid` is 0, `hazard` is 0 whatever the source numbers are, and the empty slot issues as not pending.
- R11: `hazard` depends combinationally on the decode inputs and the current slots. It changes in the same cycle the decode inputs change, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| split_rf | input | 1 | 1: register file writes early and reads late, so writeback is not compared |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_rs | input | REG_W | First source register of the decode instruction |
| dec_rt | input | REG_W | Second source register of the decode instruction |
| dec_rd | input | REG_W | Destination register of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes `dec_rd` |
| hazard | output | 1 | Read-after-write dependence on a pending write |
| hold_pc | output | 1 | Keep the program counter this cycle |
| hold_ifid | output | 1 | Keep the fetch/decode register this cycle |
| inject_bubble | output | 1 | Send an empty slot into execute at the next edge |
| ex_pend | output | 1 | Execute slot holds a pending write |
| ex_rd | output | REG_W | Destination of the execute slot |
| mem_pend | output | 1 | Memory slot holds a pending write |
| mem_rd | output | REG_W | Destination of the memory slot |
| wb_pend | output | 1 | Writeback slot holds a pending write |
| wb_rd | output | REG_W | Destination of the writeback slot |

## Verification
The assertions check the record's motion on every cycle:
- a stall always leaves a non-pending slot in execute;
- the memory and writeback slots always take their upstream neighbours;
- an unstalled valid writer always appears in execute with its destination;
- an empty decode slot, register 0 and the writeback slot in split mode never feed a hazard.

Only the bench scenarios show the end-to-end stall lengths: three cycles against an execute producer, two in split mode, one against a writeback producer. They also show that a write which has drained past writeback releases a dependent reader at once, and that rs and rt dependences count alike.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  localparam int NUM_STG = 3;
  localparam int NUM_SRC = 2;
  localparam int MAX_RW  = 16;

  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } stg_e;

  // A stage takes part in the comparison unless it is writeback while the
  // register file resolves the same-cycle write/read itself.
  function automatic logic stage_compared(input int idx, input logic split);
    return !((idx == int'(STG_WB)) && split);
  endfunction

  // One dependence term: non-zero source, pending slot, same register.
  function automatic logic dep_term(input logic [MAX_RW-1:0] src,
                                    input logic [MAX_RW-1:0] dst,
                                    input logic              pend,
                                    input logic              live);
    return live && pend && (src != '0) && (src == dst);
  endfunction

endpackage

// File: rtl/rsu_src_match.sv
module rsu_src_match #(
  parameter int REG_W = 5
) (
  input  logic                                  split_rf,
  input  logic                                  src_valid,
  input  logic [REG_W-1:0]                      src,
  input  logic [rsu_pkg::NUM_STG-1:0][REG_W-1:0] stg_rd,
  input  logic [rsu_pkg::NUM_STG-1:0]           stg_pend,
  output logic [rsu_pkg::NUM_STG-1:0]           stg_hit
);
  import rsu_pkg::*;

  localparam int PAD = MAX_RW - REG_W;

  logic [MAX_RW-1:0] src_ext;
  assign src_ext = {{PAD{1'b0}}, src};

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
    logic [MAX_RW-1:0] dst_ext;
    logic              live;
    assign dst_ext    = {{PAD{1'b0}}, stg_rd[s]};
    assign live       = stage_compared(s, split_rf);
    assign stg_hit[s] = src_valid && dep_term(src_ext, dst_ext, stg_pend[s], live);
  end

endmodule

// File: rtl/rsu_pend_pipe.sv
module rsu_pend_pipe #(
  parameter int REG_W = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bubble,
  input  logic                                  dec_valid,
  input  logic                                  dec_wen,
  input  logic [REG_W-1:0]                      dec_rd,
  output logic [rsu_pkg::NUM_STG-1:0][REG_W-1:0] stg_rd,
  output logic [rsu_pkg::NUM_STG-1:0]           stg_pend
);
  import rsu_pkg::*;

  logic             issue_pend;
  logic [REG_W-1:0] issue_rd;

  assign issue_pend = bubble ? 1'b0 : (dec_valid && dec_wen);
  assign issue_rd   = bubble ? '0 : dec_rd;

  for (genvar s = 0; s < NUM_STG; s++) begin : g_slot
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_pend[s] <= 1'b0;
          stg_rd[s]   <= '0;
        end else begin
          stg_pend[s] <= issue_pend;
          stg_rd[s]   <= issue_rd;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_pend[s] <= 1'b0;
          stg_rd[s]   <= '0;
        end else begin
          stg_pend[s] <= stg_pend[s-1];
          stg_rd[s]   <= stg_rd[s-1];
        end
      end
    end
  end

  assert_bubble_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> !stg_pend[0]);

  assert_slot_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stg_pend[1] == $past(stg_pend[0])) && (stg_rd[1] == $past(stg_rd[0])));

  assert_wb_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stg_pend[2] == $past(stg_pend[1])) && (stg_rd[2] == $past(stg_rd[1])));

  assert_issue_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bubble && dec_valid && dec_wen) |=> stg_pend[0] && (stg_rd[0] == $past(dec_rd)));

  assert_nowrite_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_wen) |=> !stg_pend[0]);

endmodule

// File: rtl/rsu_interlock.sv
module rsu_interlock (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  split_rf,
  input  logic                                  dec_valid,
  input  logic [rsu_pkg::NUM_SRC-1:0][rsu_pkg::NUM_STG-1:0] hits,
  output logic                                  hazard,
  output logic                                  hold_pc,
  output logic                                  hold_ifid,
  output logic                                  inject_bubble
);
  import rsu_pkg::*;

  logic [NUM_SRC-1:0] src_blocked;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_blocked[i] = |hits[i];
  end

  assign hazard        = |src_blocked;
  assign hold_pc       = hazard;
  assign hold_ifid     = hazard;
  assign inject_bubble = hazard;

  assert_idle_decode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !hazard);

  assert_split_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    split_rf |-> !hits[0][int'(STG_WB)] && !hits[1][int'(STG_WB)]);

  assert_freeze_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> hold_pc && hold_ifid && inject_bubble);

endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_rf,
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic [REG_W-1:0] dec_rd,
  input  logic             dec_wen,
  output logic             hazard,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             inject_bubble,
  output logic             ex_pend,
  output logic [REG_W-1:0] ex_rd,
  output logic             mem_pend,
  output logic [REG_W-1:0] mem_rd,
  output logic             wb_pend,
  output logic [REG_W-1:0] wb_rd
);
  import rsu_pkg::*;

  logic [NUM_STG-1:0][REG_W-1:0] stg_rd;
  logic [NUM_STG-1:0]            stg_pend;
  logic [NUM_SRC-1:0][REG_W-1:0] srcs;
  logic [NUM_SRC-1:0][NUM_STG-1:0] hits;

  assign srcs[0] = dec_rs;
  assign srcs[1] = dec_rt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    rsu_src_match #(.REG_W(REG_W)) u_match (
      .split_rf  (split_rf),
      .src_valid (dec_valid),
      .src       (srcs[i]),
      .stg_rd    (stg_rd),
      .stg_pend  (stg_pend),
      .stg_hit   (hits[i])
    );
  end

  rsu_interlock u_lock (
    .clk           (clk),
    .rst_n         (rst_n),
    .split_rf      (split_rf),
    .dec_valid     (dec_valid),
    .hits          (hits),
    .hazard        (hazard),
    .hold_pc       (hold_pc),
    .hold_ifid     (hold_ifid),
    .inject_bubble (inject_bubble)
  );

  rsu_pend_pipe #(.REG_W(REG_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .bubble    (inject_bubble),
    .dec_valid (dec_valid),
    .dec_wen   (dec_wen),
    .dec_rd    (dec_rd),
    .stg_rd    (stg_rd),
    .stg_pend  (stg_pend)
  );

  assign ex_pend  = stg_pend[int'(STG_EX)];
  assign ex_rd    = stg_rd[int'(STG_EX)];
  assign mem_pend = stg_pend[int'(STG_MEM)];
  assign mem_rd   = stg_rd[int'(STG_MEM)];
  assign wb_pend  = stg_pend[int'(STG_WB)];
  assign wb_rd    = stg_rd[int'(STG_WB)];

  assert_reg_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs == '0 && dec_rt == '0) |-> !hazard);

  assert_issue_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !ex_pend);

endmodule

// File: tb/raw_stall_unit_bench.sv
module raw_stall_unit_bench;

  localparam int RW = 5;

  typedef struct {
    string       tag;
    bit          hz;
    bit [2:0]    pend;
    bit [RW-1:0] rd [3];
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          split_rf = 1'b0;
  logic          dec_valid = 1'b0;
  logic [RW-1:0] dec_rs = '0, dec_rt = '0, dec_rd = '0;
  logic          dec_wen = 1'b0;
  logic          hazard, hold_pc, hold_ifid, inject_bubble;
  logic          ex_pend, mem_pend, wb_pend;
  logic [RW-1:0] ex_rd, mem_rd, wb_rd;

  raw_stall_unit #(.REG_W(RW)) u_raw_stall_unit (
    .clk(clk), .rst_n(rst_n), .split_rf(split_rf),
    .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_rd(dec_rd), .dec_wen(dec_wen),
    .hazard(hazard), .hold_pc(hold_pc), .hold_ifid(hold_ifid),
    .inject_bubble(inject_bubble),
    .ex_pend(ex_pend), .ex_rd(ex_rd), .mem_pend(mem_pend), .mem_rd(mem_rd),
    .wb_pend(wb_pend), .wb_rd(wb_rd)
  );

  always #5 clk = ~clk;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t sb_q[$];
  event sample_ev;

  // Bench-side record of in-flight writes, indexed execute, memory, writeback.
  bit          m_pend [3];
  bit [RW-1:0] m_rd   [3];

  function automatic bit model_hz();
    bit r = 0;
    if (!dec_valid) return 0;
    for (int s = 0; s < 3; s++) begin
      if (s == 2 && split_rf) continue;
      if (!m_pend[s]) continue;
      if (dec_rs != 0 && dec_rs == m_rd[s]) r = 1;
      if (dec_rt != 0 && dec_rt == m_rd[s]) r = 1;
    end
    return r;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.tag  = tag;
    e.hz   = model_hz();
    e.pend = {m_pend[2], m_pend[1], m_pend[0]};
    for (int s = 0; s < 3; s++) e.rd[s] = m_rd[s];
    sb_q.push_back(e);
    -> sample_ev;
  endtask

  // Monitor: pops each expected item and compares it with the ports.
  initial begin
    forever begin
      @(sample_ev);
      #0;
      while (sb_q.size() > 0) begin
        exp_t e;
        bit   bad;
        bit [2:0] act_p;
        e = sb_q.pop_front();
        act_p = {wb_pend, mem_pend, ex_pend};
        bad = (hazard !== e.hz) || (hold_pc !== e.hz) || (hold_ifid !== e.hz) ||
              (inject_bubble !== e.hz) || (act_p !== e.pend) ||
              (e.pend[0] && ex_rd !== e.rd[0]) ||
              (e.pend[1] && mem_rd !== e.rd[1]) ||
              (e.pend[2] && wb_rd !== e.rd[2]);
        n_vec++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s: hz/hold/bub=%0b%0b%0b%0b pend=%b rd=%0d,%0d,%0d expected hz=%0b pend=%b rd=%0d,%0d,%0d",
                   e.tag, hazard, hold_pc, hold_ifid, inject_bubble, act_p,
                   ex_rd, mem_rd, wb_rd, e.hz, e.pend, e.rd[0], e.rd[1], e.rd[2]);
        end
      end
    end
  end

  task automatic advance();
    bit hz;
    hz = model_hz();
    @(posedge clk);
    m_pend[2] = m_pend[1]; m_rd[2] = m_rd[1];
    m_pend[1] = m_pend[0]; m_rd[1] = m_rd[0];
    if (hz) begin
      m_pend[0] = 0; m_rd[0] = 0;
    end else begin
      m_pend[0] = dec_valid && dec_wen; m_rd[0] = dec_rd;
    end
  endtask

  // Present one decode instruction; keep it while the stall holds it.
  // Returns the number of stall cycles seen by the bench model.
  task automatic issue(input bit v, input bit [RW-1:0] rs, input bit [RW-1:0] rt,
                       input bit [RW-1:0] rd, input bit wen, input string tag,
                       output int stalls);
    stalls = 0;
    @(negedge clk);
    dec_valid = v; dec_rs = rs; dec_rt = rt; dec_rd = rd; dec_wen = wen;
    #1 push_exp(tag);
    while (model_hz()) begin
      stalls++;
      advance();
      @(negedge clk);
      #1 push_exp(tag);
    end
    advance();
  endtask

  task automatic count_check(input int got, input int want, input string tag);
    n_vec++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: stall cycles %0d expected %0d", tag, got, want);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
  end

  initial begin
    int st;
    for (int s = 0; s < 3; s++) begin m_pend[s] = 0; m_rd[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 push_exp("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    #1 push_exp("R1 after release");

    // R8: writer issues; R2: rs reader stalls three cycles against execute.
    issue(1, 0, 0, 5'd3, 1, "R8 writer r3", st);
    issue(1, 5'd3, 5'd0, 5'd4, 1, "R2 rs on r3", st);
    count_check(st, 3, "R2 R7 stall length");

    // R3: rt dependence behind one unrelated instruction (memory stage).
    issue(1, 0, 0, 5'd7, 1, "R8 writer r7", st);
    issue(1, 5'd1, 5'd2, 5'd8, 1, "R4 unrelated", st);
    count_check(st, 0, "R4 no match");
    issue(1, 5'd9, 5'd7, 5'd10, 1, "R3 rt on r7", st);
    count_check(st, 2, "R3 stall from memory");

    // R5: split register file, producer in execute: two stall cycles.
    split_rf = 1'b1;
    issue(1, 0, 0, 5'd12, 1, "R8 writer r12", st);
    issue(1, 5'd12, 5'd12, 5'd13, 1, "R5 split reader", st);
    count_check(st, 2, "R5 split stall");
    split_rf = 1'b0;

    // R4: non-writing producer never stalls.
    issue(1, 0, 0, 5'd14, 0, "R4 non-writer r14", st);
    issue(1, 5'd14, 5'd14, 5'd15, 1, "R4 reader r14", st);
    count_check(st, 0, "R4 no stall");

    // R6: writer of register 0, then reader of register 0.
    issue(1, 0, 0, 5'd0, 1, "R6 writer r0", st);
    issue(1, 5'd0, 5'd0, 5'd16, 1, "R6 reader r0", st);
    count_check(st, 0, "R6 no stall");

    // R10: invalid decode slot naming a pending register.
    issue(1, 0, 0, 5'd17, 1, "R8 writer r17", st);
    issue(0, 5'd17, 5'd17, 5'd17, 1, "R10 empty slot", st);
    count_check(st, 0, "R10 no stall");
    issue(1, 5'd17, 0, 5'd18, 0, "R10 reader r17 from memory", st);
    count_check(st, 2, "R10 R2 reader stalls");

    // R9: write drained past writeback releases the reader.
    issue(1, 0, 0, 5'd20, 1, "R8 writer r20", st);
    issue(1, 0, 0, 5'd0, 0, "R9 filler", st);
    issue(1, 0, 0, 5'd0, 0, "R9 filler", st);
    issue(1, 0, 0, 5'd0, 0, "R9 filler", st);
    issue(1, 5'd20, 0, 5'd21, 1, "R9 reader after drain", st);
    count_check(st, 0, "R9 released");

    // R2 from writeback, one stall cycle; with split, none.
    issue(1, 0, 0, 5'd22, 1, "R8 writer r22", st);
    issue(1, 0, 0, 5'd0, 0, "R2 filler", st);
    issue(1, 0, 0, 5'd0, 0, "R2 filler", st);
    issue(1, 5'd22, 0, 5'd23, 1, "R2 reader from writeback", st);
    count_check(st, 1, "R2 writeback stall");
    issue(1, 0, 0, 5'd24, 1, "R8 writer r24", st);
    issue(1, 0, 0, 5'd0, 0, "R5 filler", st);
    issue(1, 0, 0, 5'd0, 0, "R5 filler", st);
    split_rf = 1'b1;
    issue(1, 0, 5'd24, 5'd25, 1, "R5 writeback skipped", st);
    count_check(st, 0, "R5 no stall");
    split_rf = 1'b0;

    // R11: decode inputs change mid-cycle; hazard follows without an edge.
    issue(1, 0, 0, 5'd26, 1, "R8 writer r26", st);
    @(negedge clk);
    dec_valid = 1; dec_rs = 5'd1; dec_rt = 5'd2; dec_rd = 5'd0; dec_wen = 0;
    #1 push_exp("R11 before change");
    #2 dec_rt = 5'd26;
    #1 push_exp("R11 after change");
    advance();
    dec_valid = 0;
    repeat (4) advance();
    done = 1;
  end

  initial begin
    wait (done);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule